// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out Flag

This block shifts a 32-bit operand left, right with zero fill, or right with sign fill, by a count of 0 to 31, and produces the shifted word together with zero, sign, carry and overflow flags. The shift itself is a logarithmic barrel of combinational stages. One register stage, loaded under a clock enable, holds the result and the flags.

The count comes from one of two places. It can be a 5-bit immediate taken as an unsigned value, or the low five bits of a full register value, so the count wraps modulo the word width. Carry holds the last bit that leaves the word. For a left shift that is a different operand bit than for a right shift. A count of zero moves no bit out and clears carry. Overflow is cleared by every shift.

Top module: `shift_flag_unit`

## Requirements
- R1: When `use_imm` is 1 the count is `imm_amt`; when it is 0 the count is `amt_reg[4:0]`, and bits 31:5 of `amt_reg` have no effect on any output.
- R2: Operation code `op_sel` = 2'b00 shifts the operand left and fills the vacated low bits with zeros.
- R3: Operation code 2'b01 shifts right and fills the vacated high bits with zeros.
- R4: Operation code 2'b10 shifts right and fills the vacated high bits with copies of operand bit 31.
- R5: For a left shift by a count n from 1 to 31, `flag_cy` equals operand bit (32 - n).
- R6: For either right shift by a count n from 1 to 31, `flag_cy` equals operand bit (n - 1).
- R7: A count of zero gives a result equal to the operand and clears `flag_cy`, for every operation code.
- R8: `flag_z` is 1 exactly when the result is all zeros, and `flag_s` equals result bit 31.
- R9: `flag_ov` is 0 after every shift.
- R10: The result and flags appear on the outputs one clock edge after the edge that samples `in_valid` = 1. `out_valid` is `in_valid` delayed by one edge. While `in_valid` is 0 the result and flags hold their values.
- R11: While `rst_n` is low, `out_valid`, `result` and all four flags are 0.
- R12: The reserved operation code 2'b11 behaves exactly as code 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Clock enable: load a new shift result on this edge |
| op_sel | input | 2 | Operation: 00 left, 01 right logical, 10 right arithmetic, 11 as 01 |
| use_imm | input | 1 | Take the count from `imm_amt` instead of `amt_reg` |
| imm_amt | input | 5 | Unsigned immediate count |
| amt_reg | input | 32 | Register value whose low five bits give the count |
| operand | input | 32 | Word to be shifted |
| out_valid | output | 1 | Result registers were loaded on the previous edge |
| result | output | 32 | Shifted word |
| flag_z | output | 1 | Result is zero |
| flag_s | output | 1 | Result bit 31 |
| flag_cy | output | 1 | Last bit shifted out |
| flag_ov | output | 1 | Overflow, always cleared |

## Verification
The assertions assume that every input is a known 0 or 1 at the sampling edge. They also assume that `rst_n` is released while `in_valid` is low, so that the first registered result is a real shift and not the reset value. The stimulus changes inputs only on the falling clock edge, drives only defined values, and raises `in_valid` only after reset is released. Every count from 0 to 31 is swept for each operation code. Random register counts carry random garbage in bits 31:5.

// File: rtl/shift_flag_pkg.sv
package shift_flag_pkg;

  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_SHR = 2'b01,
    OP_SAR = 2'b10,
    OP_RSV = 2'b11
  } shift_op_e;

  typedef struct packed {
    logic z;
    logic s;
    logic cy;
    logic ov;
  } shift_flags_t;

endpackage

// File: rtl/sfu_amount_sel.sv
module sfu_amount_sel #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              use_imm,
  input  logic [AMT_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] amt_reg,
  output logic [AMT_W-1:0]  amt
);

  localparam logic [DATA_W-1:0] WRAP = DATA_W[DATA_W-1:0];

  logic [DATA_W-1:0] reg_wrapped;

  // DATA_W is a power of two, so the modulo keeps only the low count bits.
  always_comb begin
    reg_wrapped = amt_reg % WRAP;
    amt         = use_imm ? imm_amt : reg_wrapped[AMT_W-1:0];
  end

endmodule

// File: rtl/sfu_core.sv
module sfu_core
  import shift_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  amt,
  input  shift_op_e         op,
  output logic [DATA_W-1:0] shifted
);

  logic go_left;
  logic fill;
  logic [AMT_W:0][DATA_W-1:0] stage;
  logic [DATA_W-1:0] flipped_in;
  logic [DATA_W-1:0] last;

  assign go_left = (op == OP_SHL);
  assign fill    = (op == OP_SAR) & operand[DATA_W-1];

  // A left shift is a right shift of the bit-reversed word.
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      flipped_in[i] = go_left ? operand[DATA_W-1-i] : operand[i];
    end
  end

  assign stage[0] = flipped_in;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amt[k] ? {{SH{fill}}, stage[k][DATA_W-1:SH]} : stage[k];
  end

  assign last = stage[AMT_W];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      shifted[i] = go_left ? last[DATA_W-1-i] : last[i];
    end
  end

endmodule

// File: rtl/sfu_flags.sv
module sfu_flags
  import shift_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  amt,
  input  shift_op_e         op,
  input  logic [DATA_W-1:0] shifted,
  output shift_flags_t      flags
);

  logic [AMT_W-1:0] idx_left;
  logic [AMT_W-1:0] idx_right;
  logic             carry;

  always_comb begin
    idx_left  = AMT_W'(DATA_W - int'(amt));
    idx_right = amt - 1'b1;
    if (amt == '0) begin
      carry = 1'b0;
    end else if (op == OP_SHL) begin
      carry = operand[idx_left];
    end else begin
      carry = operand[idx_right];
    end
  end

  always_comb begin
    flags.z  = (shifted == '0);
    flags.s  = shifted[DATA_W-1];
    flags.cy = carry;
    flags.ov = 1'b0;
  end

  // Sign fill of the arithmetic shift is produced by the barrel, checked here.
  always_comb begin
    if (op == OP_SAR && operand[DATA_W-1]) begin
      assert_sar_sign_fill_R4: assert (shifted[DATA_W-1] == 1'b1);
    end
  end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shift_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic              use_imm,
  input  logic [AMT_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] amt_reg,
  input  logic [DATA_W-1:0] operand,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_cy,
  output logic              flag_ov
);

  shift_op_e         op;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] shifted;
  shift_flags_t      flags_c;

  logic [DATA_W-1:0] res_q, res_d;
  shift_flags_t      flg_q, flg_d;
  logic              vld_q, vld_d;

  assign op = shift_op_e'(op_sel);

  sfu_amount_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt (
    .use_imm (use_imm),
    .imm_amt (imm_amt),
    .amt_reg (amt_reg),
    .amt     (amt)
  );

  sfu_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .operand (operand),
    .amt     (amt),
    .op      (op),
    .shifted (shifted)
  );

  sfu_flags #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_flags (
    .operand (operand),
    .amt     (amt),
    .op      (op),
    .shifted (shifted),
    .flags   (flags_c)
  );

  // Next-state logic with the clock enable written out.
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    flg_d = flg_q;
    if (in_valid) begin
      res_d = shifted;
      flg_d = flags_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign flag_z    = flg_q.z;
  assign flag_s    = flg_q.s;
  assign flag_cy   = flg_q.cy;
  assign flag_ov   = flg_q.ov;

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_z == (result == '0)));

  assert_sign_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_s == result[DATA_W-1]));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !flag_ov);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flag_cy) && $stable(flag_z)));

  assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && amt == '0) |=> (result == $past(operand) && !flag_cy));

endmodule

// File: tb/shift_flag_unit_tb.sv
`timescale 1ns/1ps
module shift_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op_sel;
  logic        use_imm;
  logic [4:0]  imm_amt;
  logic [31:0] amt_reg;
  logic [31:0] operand;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_z, flag_s, flag_cy, flag_ov;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  shift_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .use_imm(use_imm), .imm_amt(imm_amt), .amt_reg(amt_reg), .operand(operand),
    .out_valid(out_valid), .result(result), .flag_z(flag_z), .flag_s(flag_s),
    .flag_cy(flag_cy), .flag_ov(flag_ov)
  );

  function automatic logic [31:0] model_res(input logic [1:0] op, input logic [31:0] v,
                                            input int n);
    if (op == 2'b00)      return v << n;
    else if (op == 2'b10) return 32'($signed(v) >>> n);
    else                  return v >> n;
  endfunction

  function automatic logic model_cy(input logic [1:0] op, input logic [31:0] v, input int n);
    if (n == 0)           return 1'b0;
    else if (op == 2'b00) return v[32-n];
    else                  return v[n-1];
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] op, input logic imm_sel,
                     input logic [4:0] imm, input logic [31:0] regv, input logic [31:0] v);
    int n;
    logic [31:0] er;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; use_imm = imm_sel; imm_amt = imm;
    amt_reg = regv; operand = v;
    @(negedge clk);
    in_valid = 1'b0;
    n  = imm_sel ? int'(imm) : int'(regv[4:0]);
    er = model_res(op, v, n);
    check(req, "result", result, er);
    check(req, "carry", {31'b0, flag_cy}, {31'b0, model_cy(op, v, n)});
    check("R8", "zero", {31'b0, flag_z}, {31'b0, er == 32'b0});
    check("R8", "sign", {31'b0, flag_s}, {31'b0, er[31]});
    check("R9", "overflow", {31'b0, flag_ov}, 32'b0);
    check("R10", "out_valid", {31'b0, out_valid}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_r;
    logic        hold_c;
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 2'b00; use_imm = 1'b1;
    imm_amt = 5'd0; amt_reg = 32'h0; operand = 32'h0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "out_valid", {31'b0, out_valid}, 32'b0);
    check("R11", "result", result, 32'b0);
    check("R11", "flags", {28'b0, flag_z, flag_s, flag_cy, flag_ov}, 32'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R5 left, R3 R6 logical right, R4 R6 arithmetic right: full count sweep
    for (int a = 0; a < 32; a++) run(a == 0 ? "R7" : "R2_R5", 2'b00, 1'b1, 5'(a), 32'h0, $urandom());
    for (int a = 0; a < 32; a++) run(a == 0 ? "R7" : "R3_R6", 2'b01, 1'b1, 5'(a), 32'h0, $urandom());
    for (int a = 0; a < 32; a++) run(a == 0 ? "R7" : "R4_R6", 2'b10, 1'b1, 5'(a), 32'h0, $urandom() | 32'h8000_0000);
    for (int a = 0; a < 32; a++) run("R4_R6", 2'b10, 1'b1, 5'(a), 32'h0, $urandom() & 32'h7fff_ffff);
    // R12: reserved code acts as logical right
    for (int a = 0; a < 32; a++) run("R12", 2'b11, 1'b1, 5'(a), 32'h0, $urandom() | 32'h8000_0000);

    // Directed corners
    run("R5", 2'b00, 1'b1, 5'd1, 32'h0, 32'h8000_0000);
    run("R5", 2'b00, 1'b1, 5'd31, 32'h0, 32'h0000_0002);
    run("R6", 2'b01, 1'b1, 5'd1, 32'h0, 32'h0000_0001);
    run("R6", 2'b10, 1'b1, 5'd31, 32'h0, 32'h4000_0000);
    run("R7", 2'b10, 1'b1, 5'd0, 32'h0, 32'hffff_ffff);
    run("R8", 2'b01, 1'b1, 5'd31, 32'h0, 32'h7fff_ffff);

    // R1: register count with garbage upper bits, and immediate ignoring the register
    for (int i = 0; i < 40; i++) run("R1", 2'($urandom_range(0, 3)), 1'b0, 5'($urandom()), $urandom(), $urandom());
    run("R1", 2'b00, 1'b0, 5'd3, 32'hffff_ffe0, 32'h1234_5678);
    run("R1", 2'b01, 1'b1, 5'd4, 32'hffff_ffff, 32'h1234_5678);

    // Random mix
    for (int i = 0; i < 100; i++) run("R2_R3_R4", 2'($urandom_range(0, 3)), 1'b1, 5'($urandom()), 32'h0, $urandom());

    // R10: hold while in_valid is low
    run("R10", 2'b00, 1'b1, 5'd4, 32'h0, 32'h8765_4321);
    hold_r = result; hold_c = flag_cy;
    @(negedge clk);
    op_sel = 2'b01; imm_amt = 5'd7; operand = 32'hdead_beef;
    repeat (3) @(negedge clk);
    check("R10", "held result", result, hold_r);
    check("R10", "held carry", {31'b0, flag_cy}, {31'b0, hold_c});
    check("R10", "out_valid low", {31'b0, out_valid}, 32'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule